// File: doc/BRIEF.md
# Strided ATA Task-File Bus Bridge

This block sits between a memory-mapped host window and an ATA-style task-file register set with a 32-bit data port. Each host access carries a byte address, a read or write strobe, a size code and data. The block turns it into at most one strobe on the device side. The device side offers task-file access, a device-control write, an alternate-status read and a data-port transfer. Registers are spread 16 bytes apart, so the slot number is taken from address bits above the low nibble.

Two slot numbers both reach the control/alt-status register. The data port answers only halfword and word accesses. For a big-endian host, the data-port byte lanes are reversed in both directions. Unmapped reads return all-ones fill values sized to the access. The endianness select is captured while reset is asserted and is ignored afterwards. Read data returns registered, one cycle after the read, together with a valid pulse.

Top module: `stride_ata_bridge`

## Requirements
- R1: The slot number is address bits [11:4]. Bits [3:0] and bits 12 and up have no effect on decoding. `dev_reg_o` carries slot bits [2:0].
- R2: A byte access (size code 0) to slot 1 to 7 asserts `dev_tf_wr_o` or `dev_tf_rd_o` with `dev_reg_o` equal to the slot. For writes, `dev_wdata_o` is host data bits [7:0] zero-extended.
- R3: A byte access to slot 8 or slot 22 asserts `dev_ctl_wr_o` on a write and `dev_alt_rd_o` on a read.
- R4: A byte read at any other slot returns 0x000000FF. A byte write there asserts no device strobe.
- R5: Halfword (size code 1) and word (size code 2) accesses at slot 0 assert `dev_data_wr_o` or `dev_data_rd_o`, with `dev_data_word_o` high for word and low for halfword. At any other slot, reads return 0x0000FFFF (halfword) or 0xFFFFFFFF (word), and writes assert no strobe.
- R6: In big-endian mode, data-port values are byte-reversed in both directions: the 2 low bytes for a halfword, all 4 bytes for a word. In little-endian mode they pass unchanged. Halfword values are zero-extended.
- R7: A read (`host_rd_i` high with `host_wr_i` low) gives `host_rvalid_o` high for exactly the next cycle. The data appears in `host_rdata_o` in that same cycle, and byte reads are zero-extended from device bits [7:0].
- R8: At most one device strobe is high in any cycle. When read and write are both asserted, the write wins. A byte access never asserts a data-port strobe.
- R9: The big-endian select `be_mode_i` is captured while `rst_n` is low. Changing it after reset has no effect.
- R10: Size code 3 is reserved. It asserts no device strobe, and a read returns 0xFFFFFFFF.
- R11: Reset clears `host_rvalid_o` and `host_rdata_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| be_mode_i | input | 1 | Big-endian select, captured during reset |
| host_addr_i | input | 32 | Host byte address |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Registered read data |
| host_rvalid_o | output | 1 | Read data valid pulse |
| dev_reg_o | output | 3 | Task-file register number |
| dev_wdata_o | output | 32 | Write data to device |
| dev_rdata_i | input | 32 | Read data from device, valid during a read strobe |
| dev_tf_wr_o | output | 1 | Task-file register write |
| dev_tf_rd_o | output | 1 | Task-file register read |
| dev_ctl_wr_o | output | 1 | Device-control write |
| dev_alt_rd_o | output | 1 | Alternate-status read |
| dev_data_wr_o | output | 1 | Data-port write |
| dev_data_rd_o | output | 1 | Data-port read |
| dev_data_word_o | output | 1 | Data-port width, 1 = 32-bit |

## Verification
The hardest case to reach is the effect of `be_mode_i` changing after reset. Only the data-port lane order can show whether the captured value was kept.

The bench releases reset with one endianness and then immediately drives the opposite value on `be_mode_i`. It then sweeps every slot, every size code and every operation (read, write, read and write together), with host address bits above and below the slot varied on each access. Each data-port result is checked against the endianness captured at reset. The sweep is run once per endianness.

// File: rtl/ata_bridge_pkg.sv
package ata_bridge_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_TASK   = 3'd1,
        CLS_CTRL   = 3'd2,
        CLS_DATA16 = 3'd3,
        CLS_DATA32 = 3'd4
    } slot_cls_e;

    typedef struct packed {
        logic [31:0] rdata;
        logic        rvalid;
        logic        be;
    } bridge_state_t;

endpackage

// File: rtl/ata_addr_decode.sv
module ata_addr_decode
    import ata_bridge_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int WIN_BITS    = 12,
    parameter int STRIDE_LOG2 = 4,
    parameter int CTL_SLOT_A  = 8,
    parameter int CTL_SLOT_B  = 22,
    parameter int TF_FIRST    = 1,
    parameter int TF_LAST     = 7
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output slot_cls_e         cls_o,
    output logic [2:0]        reg_o
);
    localparam int IDX_W = WIN_BITS - STRIDE_LOG2;

    logic [IDX_W-1:0] slot;
    assign slot  = addr_i[WIN_BITS-1:STRIDE_LOG2];
    assign reg_o = slot[2:0];

    always_comb begin
        cls_o = CLS_NONE;
        case (acc_size_e'(size_i))
            SZ_BYTE: begin
                if (slot >= IDX_W'(TF_FIRST) && slot <= IDX_W'(TF_LAST))
                    cls_o = CLS_TASK;
                else if (slot == IDX_W'(CTL_SLOT_A) || slot == IDX_W'(CTL_SLOT_B))
                    cls_o = CLS_CTRL;
            end
            SZ_HALF: if (slot == '0) cls_o = CLS_DATA16;
            SZ_WORD: if (slot == '0) cls_o = CLS_DATA32;
            default: cls_o = CLS_NONE;
        endcase
    end
endmodule

// File: rtl/ata_lane_swap.sv
module ata_lane_swap #(
    parameter int BYTES = 2
) (
    input  logic [8*BYTES-1:0] in_i,
    input  logic               en_i,
    output logic [8*BYTES-1:0] out_o
);
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign out_o[8*i +: 8] = en_i ? in_i[8*(BYTES-1-i) +: 8] : in_i[8*i +: 8];
    end
endmodule

// File: rtl/stride_ata_bridge.sv
module stride_ata_bridge
    import ata_bridge_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int WIN_BITS    = 12,
    parameter int STRIDE_LOG2 = 4,
    parameter int CTL_SLOT_A  = 8,
    parameter int CTL_SLOT_B  = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              be_mode_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic              host_wr_i,
    input  logic              host_rd_i,
    input  logic [1:0]        host_size_i,
    input  logic [31:0]       host_wdata_i,
    output logic [31:0]       host_rdata_o,
    output logic              host_rvalid_o,
    output logic [2:0]        dev_reg_o,
    output logic [31:0]       dev_wdata_o,
    input  logic [31:0]       dev_rdata_i,
    output logic              dev_tf_wr_o,
    output logic              dev_tf_rd_o,
    output logic              dev_ctl_wr_o,
    output logic              dev_alt_rd_o,
    output logic              dev_data_wr_o,
    output logic              dev_data_rd_o,
    output logic              dev_data_word_o
);
    localparam logic [31:0] FILL_BYTE = 32'h0000_00FF;
    localparam logic [31:0] FILL_HALF = 32'h0000_FFFF;
    localparam logic [31:0] FILL_WORD = 32'hFFFF_FFFF;

    bridge_state_t st_d, st_q;
    slot_cls_e     cls;
    logic          wr_go, rd_go, is_data;
    logic [15:0]   wsw16, rsw16;
    logic [31:0]   wsw32, rsw32;

    ata_addr_decode #(
        .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .STRIDE_LOG2(STRIDE_LOG2),
        .CTL_SLOT_A(CTL_SLOT_A), .CTL_SLOT_B(CTL_SLOT_B),
        .TF_FIRST(1), .TF_LAST(7)
    ) u_dec (
        .addr_i(host_addr_i), .size_i(host_size_i), .cls_o(cls), .reg_o(dev_reg_o)
    );

    ata_lane_swap #(.BYTES(2)) u_wsw16 (.in_i(host_wdata_i[15:0]), .en_i(st_q.be), .out_o(wsw16));
    ata_lane_swap #(.BYTES(4)) u_wsw32 (.in_i(host_wdata_i),       .en_i(st_q.be), .out_o(wsw32));
    ata_lane_swap #(.BYTES(2)) u_rsw16 (.in_i(dev_rdata_i[15:0]),  .en_i(st_q.be), .out_o(rsw16));
    ata_lane_swap #(.BYTES(4)) u_rsw32 (.in_i(dev_rdata_i),        .en_i(st_q.be), .out_o(rsw32));

    // Write takes precedence when both host strobes are high.
    assign wr_go   = host_wr_i;
    assign rd_go   = host_rd_i && !host_wr_i;
    assign is_data = (cls == CLS_DATA16) || (cls == CLS_DATA32);

    assign dev_tf_wr_o     = wr_go && (cls == CLS_TASK);
    assign dev_tf_rd_o     = rd_go && (cls == CLS_TASK);
    assign dev_ctl_wr_o    = wr_go && (cls == CLS_CTRL);
    assign dev_alt_rd_o    = rd_go && (cls == CLS_CTRL);
    assign dev_data_wr_o   = wr_go && is_data;
    assign dev_data_rd_o   = rd_go && is_data;
    assign dev_data_word_o = (cls == CLS_DATA32);

    always_comb begin
        case (cls)
            CLS_TASK, CLS_CTRL: dev_wdata_o = {24'h0, host_wdata_i[7:0]};
            CLS_DATA16:         dev_wdata_o = {16'h0, wsw16};
            CLS_DATA32:         dev_wdata_o = wsw32;
            default:            dev_wdata_o = '0;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_go;
        if (rd_go) begin
            case (cls)
                CLS_TASK, CLS_CTRL: st_d.rdata = {24'h0, dev_rdata_i[7:0]};
                CLS_DATA16:         st_d.rdata = {16'h0, rsw16};
                CLS_DATA32:         st_d.rdata = rsw32;
                default: begin
                    case (acc_size_e'(host_size_i))
                        SZ_BYTE: st_d.rdata = FILL_BYTE;
                        SZ_HALF: st_d.rdata = FILL_HALF;
                        default: st_d.rdata = FILL_WORD;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rdata  <= '0;
            st_q.rvalid <= 1'b0;
            st_q.be     <= be_mode_i;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata_o  = st_q.rdata;
    assign host_rvalid_o = st_q.rvalid;

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dev_tf_wr_o, dev_tf_rd_o, dev_ctl_wr_o, dev_alt_rd_o,
                    dev_data_wr_o, dev_data_rd_o}) <= 1); // R8
    AST_BYTE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (host_size_i == 2'd0) |-> !(dev_data_wr_o || dev_data_rd_o)); // R8
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && !host_wr_i) |=> host_rvalid_o); // R7
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd_i && !host_wr_i) |=> !host_rvalid_o); // R7
    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (host_size_i == 2'd3) |-> !(dev_tf_wr_o || dev_tf_rd_o || dev_ctl_wr_o ||
                                    dev_alt_rd_o || dev_data_wr_o || dev_data_rd_o)); // R10
    AST_WIDE_OFF_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (host_size_i != 2'd0 && host_addr_i[WIN_BITS-1:STRIDE_LOG2] != '0) |->
        !(dev_tf_wr_o || dev_tf_rd_o || dev_ctl_wr_o || dev_alt_rd_o ||
          dev_data_wr_o || dev_data_rd_o)); // R5
endmodule

// File: tb/sim_stride_ata_bridge.sv
module sim_stride_ata_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        be_mode_i = 1'b0;
    logic [31:0] host_addr_i = '0;
    logic        host_wr_i = 1'b0, host_rd_i = 1'b0;
    logic [1:0]  host_size_i = '0;
    logic [31:0] host_wdata_i = '0;
    logic [31:0] host_rdata_o, dev_wdata_o, dev_rdata_i;
    logic        host_rvalid_o;
    logic [2:0]  dev_reg_o;
    logic        dev_tf_wr_o, dev_tf_rd_o, dev_ctl_wr_o, dev_alt_rd_o;
    logic        dev_data_wr_o, dev_data_rd_o, dev_data_word_o;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    // Device model: distinct values per register class, with junk in the upper bits.
    always_comb begin
        if (dev_tf_rd_o)        dev_rdata_i = {24'hEEEEEE, 5'b10100, dev_reg_o};
        else if (dev_alt_rd_o)  dev_rdata_i = 32'hEEEEEE5C;
        else if (dev_data_rd_o) dev_rdata_i = 32'h11223344;
        else                    dev_rdata_i = 32'hDEADBEEF;
    end

    stride_ata_bridge u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // class: 0 none, 1 task, 2 ctrl, 3 data16, 4 data32
    function automatic int cls_of(input int slot, input int sz);
        if (sz == 0) begin
            if (slot >= 1 && slot <= 7) return 1;
            if (slot == 8 || slot == 22) return 2;
            return 0;
        end
        if (sz == 1 && slot == 0) return 3;
        if (sz == 2 && slot == 0) return 4;
        return 0;
    endfunction

    function automatic string req_of(input int c, input int sz);
        case (c)
            1: return "R2";
            2: return "R3";
            3, 4: return "R6";
            default: return (sz == 3) ? "R10" : (sz == 0 ? "R4" : "R5");
        endcase
    endfunction

    task automatic access(input int slot, input int sz, input int op, input bit be);
        logic [31:0] wd, exp_w, exp_r;
        logic [5:0]  exp_s, act_s;
        int          c;
        bit          w, r;
        string       rq;
        c  = cls_of(slot, sz);
        rq = req_of(c, sz);
        w  = (op != 1);
        r  = (op != 0);
        wd = {slot[7:0], 8'h96, ~slot[7:0], 6'h0, sz[1:0]};
        @(negedge clk);
        host_addr_i  = {20'(slot * 7 + op + 3), slot[7:0], 4'(slot + sz)}; // R1 aliasing
        host_size_i  = sz[1:0];
        host_wdata_i = wd;
        host_wr_i    = w;
        host_rd_i    = r;
        #1;
        exp_s = '0;
        if (w) begin
            if (c == 1) exp_s[5] = 1'b1;
            if (c == 2) exp_s[3] = 1'b1;
            if (c >= 3) exp_s[1] = 1'b1;
        end else begin
            if (c == 1) exp_s[4] = 1'b1;
            if (c == 2) exp_s[2] = 1'b1;
            if (c >= 3) exp_s[0] = 1'b1;
        end
        act_s = {dev_tf_wr_o, dev_tf_rd_o, dev_ctl_wr_o, dev_alt_rd_o, dev_data_wr_o, dev_data_rd_o};
        // R8: write wins when both strobes are high; R1 slot decode
        chk(act_s == exp_s, (op == 2) ? "R8" : rq, 32'(act_s), 32'(exp_s));
        if (c == 1) chk(dev_reg_o == slot[2:0], "R1", 32'(dev_reg_o), 32'(slot[2:0]));
        if (c >= 3) chk(dev_data_word_o == (c == 4), "R5", 32'(dev_data_word_o), 32'(c == 4));
        if (w && c != 0) begin
            case (c)
                1, 2:    exp_w = {24'h0, wd[7:0]};
                3:       exp_w = be ? {16'h0, wd[7:0], wd[15:8]} : {16'h0, wd[15:0]};
                default: exp_w = be ? {wd[7:0], wd[15:8], wd[23:16], wd[31:24]} : wd;
            endcase
            chk(dev_wdata_o === exp_w, (c >= 3) ? "R9" : rq, dev_wdata_o, exp_w);
        end
        @(negedge clk);
        host_wr_i = 1'b0;
        host_rd_i = 1'b0;
        #1;
        chk(host_rvalid_o == (op == 1), "R7", 32'(host_rvalid_o), 32'(op == 1));
        if (op == 1) begin
            case (c)
                1:       exp_r = {24'h0, 5'b10100, slot[2:0]};
                2:       exp_r = 32'h0000005C;
                3:       exp_r = be ? 32'h00004433 : 32'h00003344;
                4:       exp_r = be ? 32'h44332211 : 32'h11223344;
                default: exp_r = (sz == 0) ? 32'hFF : (sz == 1 ? 32'hFFFF : 32'hFFFFFFFF);
            endcase
            chk(host_rdata_o === exp_r, (c >= 3) ? "R9" : rq, host_rdata_o, exp_r);
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++) begin
            @(negedge clk);
            rst_n = 1'b0;
            be_mode_i = b[0];
            #1;
            // R11: reset clears registered outputs
            chk(host_rvalid_o == 1'b0 && host_rdata_o == '0, "R11", host_rdata_o, 32'h0);
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
            be_mode_i = ~b[0]; // R9: must be ignored after reset
            for (int slot = 0; slot < 256; slot++)
                for (int sz = 0; sz < 4; sz++)
                    for (int op = 0; op < 3; op++)
                        access(slot, sz, op, b[0]);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule